// File: doc/BRIEF.md
# Outstanding-Read Occupancy Monitor

This block sits beside a read master port and measures how deeply that port pipelines its reads. It watches two single-cycle strobes, one for each accepted read request and one for each returned read response, and keeps a live count of the reads that are currently outstanding. From that count it builds three statistics: the highest outstanding count reached, the number of cycles in which at least one read was outstanding, and the sum of the outstanding count over those cycles. Dividing the sum by the active-cycle count gives the mean concurrency while busy. The peak gives the worst case.

Software works the block through a small word-addressed register port. A control word starts and stops counting and can zero every counter. Read windows expose the statistics as 32-bit words, and one of them packs the peak beside the upper active-cycle bits. A write to that packed word zeroes only the peak, so software can take repeated peak samples without losing the running totals. Counters are meant to be read and cleared while counting is stopped.

Top module: `rdocc_monitor`

## Requirements
- R1: After reset, counting is off, and all registers and counters read zero.
- R2: While counting is on, an accepted request raises the outstanding count by one and a returned response lowers it by one. A request and a response in the same cycle leave the count unchanged.
- R3: The outstanding count stops at its all-ones value (2^CNT_W-1) and does not wrap. A response that arrives at a count of zero leaves the count at zero.
- R4: The peak equals the largest outstanding count, taken after each cycle's update, since the last clear.
- R5: Each enabled cycle that begins with a nonzero outstanding count adds that count to the 64-bit cumulative sum.
- R6: Each enabled cycle that begins with a nonzero outstanding count increments the active-cycle counter by one.
- R7: While counting is off, all counters hold their values and request and response strobes are ignored.
- R8: Register map by word address. 0 is control: bit 0 is the enable (read/write), and every other bit reads 0. 1 holds active cycles [31:0]. 2 is the packed word: bits 31:27 read 0, bits 26:16 hold the peak and bits 15:0 hold active cycles [47:32]. 3 holds sum [31:0]. 4 holds sum [63:32]. Addresses 5 to 7 read zero, and writes to them have no effect.
- R9: A write of any value to address 2 zeroes the peak in that cycle and leaves the outstanding count, the sum, the active-cycle count and the enable unchanged. The clear takes priority over any peak update in the same cycle.
- R10: A control write with bit 1 set zeroes all four counters. The same write loads the enable from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_acc | input | 1 | A read request was accepted this cycle |
| rd_rsp_ret | input | 1 | A read response returned this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
A write to the packed word, which clears the peak, can fall in the same cycle as a request that would raise the peak. The bench provokes this by driving a request while it writes to that word. It expects the peak to read zero afterwards while the outstanding count has still moved up. A request and a response can also land in the same cycle, at zero, at mid-range and at saturation. The bench judges those cycles through later sum and active-cycle readings taken against an arithmetic model.

// File: rtl/rdocc_pkg.sv
package rdocc_pkg;

    localparam int REG_AW     = 3;
    localparam int PEAK_LSB   = 16;
    localparam int PEAK_FLD_W = 11;
    localparam int ACT_HI_W   = 16;

    localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] RA_ACT_LO = 3'd1;
    localparam logic [REG_AW-1:0] RA_PACK   = 3'd2;
    localparam logic [REG_AW-1:0] RA_SUM_LO = 3'd3;
    localparam logic [REG_AW-1:0] RA_SUM_HI = 3'd4;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef struct packed {
        logic enable;
        logic clr_all;
        logic clr_peak;
    } ctrl_t;

    typedef struct packed {
        logic req;
        logic rsp;
    } evt_t;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_UP   = 2'b10,
        OCC_DOWN = 2'b01,
        OCC_BOTH = 2'b11
    } occ_step_e;

    function automatic occ_step_e classify(input evt_t e);
        return occ_step_e'({e.req, e.rsp});
    endfunction

endpackage

// File: rtl/rdocc_inflight.sv
module rdocc_inflight
    import rdocc_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctl,
    input  evt_t             evt,
    output logic [CNT_W-1:0] inf_q,
    output logic [CNT_W-1:0] peak_q
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] inf_d;
    occ_step_e        step;

    assign step = classify(evt);

    always_comb begin
        inf_d = inf_q;
        if (ctl.enable) begin
            case (step)
                OCC_UP:   if (inf_q != MAXV) inf_d = inf_q + 1'b1;
                OCC_DOWN: if (inf_q != '0)   inf_d = inf_q - 1'b1;
                default:  inf_d = inf_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr_all) inf_q <= '0;
        else                    inf_q <= inf_d;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr_all || ctl.clr_peak) peak_q <= '0;
        else if (ctl.enable && (inf_d > peak_q)) peak_q <= inf_d;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !ctl.clr_all && evt.req && !evt.rsp && inf_q == MAXV) |=> (inf_q == MAXV)); // R3
    AST_NO_UNDER: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !ctl.clr_all && evt.rsp && !evt.req && inf_q == '0) |=> (inf_q == '0)); // R3
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr_all && evt.req && evt.rsp) |=> $stable(inf_q)); // R2
    AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !ctl.clr_all && !ctl.clr_peak && peak_q >= inf_q) |=> (peak_q >= inf_q)); // R4
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.enable && !ctl.clr_all && !ctl.clr_peak) |=> ($stable(inf_q) && $stable(peak_q))); // R7
    AST_PEAK_CLR: assert property (@(posedge clk) disable iff (rst)
        ctl.clr_peak |=> (peak_q == '0)); // R9

endmodule

// File: rtl/rdocc_integrator.sv
module rdocc_integrator
    import rdocc_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int ACT_W = 48,
    parameter int SUM_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctl,
    input  logic [CNT_W-1:0] inf_q,
    output logic [ACT_W-1:0] act_q,
    output logic [SUM_W-1:0] sum_q
);
    logic             busy;
    logic [SUM_W-1:0] inf_ext;
    logic             unused_ctl;

    assign busy       = ctl.enable && (inf_q != '0);
    assign inf_ext    = SUM_W'(inf_q);
    assign unused_ctl = ctl.clr_peak;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr_all) begin
            act_q <= '0;
            sum_q <= '0;
        end else if (busy) begin
            act_q <= act_q + 1'b1;
            sum_q <= sum_q + inf_ext;
        end
    end

    AST_SUM_GE_ACT: assert property (@(posedge clk) disable iff (rst)
        (sum_q >= SUM_W'(act_q))); // R5
    AST_ACT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !ctl.clr_all && inf_q != '0) |=> (act_q != $past(act_q))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr_all && (!ctl.enable || inf_q == '0)) |=> ($stable(act_q) && $stable(sum_q))); // R7

endmodule

// File: rtl/rdocc_regs.sv
module rdocc_regs
    import rdocc_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int ACT_W = 48,
    parameter int SUM_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  peak_q,
    input  logic [ACT_W-1:0]  act_q,
    input  logic [SUM_W-1:0]  sum_q,
    output ctrl_t             ctl,
    output logic [31:0]       rdata
);
    logic                  en_q;
    logic [63:0]           act_x;
    logic [63:0]           sum_x;
    logic [PEAK_FLD_W-1:0] peak_f;
    logic                  unused_bits;

    assign act_x       = 64'(act_q);
    assign sum_x       = 64'(sum_q);
    assign peak_f      = PEAK_FLD_W'(peak_q);
    assign unused_bits = ^{wdata[31:2], act_x[63:48]};

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else if (wr_en && addr == RA_CTRL) en_q <= wdata[CTRL_EN_BIT];
    end

    assign ctl.enable   = en_q;
    assign ctl.clr_all  = wr_en && (addr == RA_CTRL) && wdata[CTRL_CLR_BIT];
    assign ctl.clr_peak = wr_en && (addr == RA_PACK);

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL:   rdata[CTRL_EN_BIT] = en_q;
            RA_ACT_LO: rdata = act_x[31:0];
            RA_PACK: begin
                rdata[PEAK_LSB +: PEAK_FLD_W] = peak_f;
                rdata[ACT_HI_W-1:0]           = act_x[32 +: ACT_HI_W];
            end
            RA_SUM_LO: rdata = sum_x[31:0];
            RA_SUM_HI: rdata = sum_x[63:32];
            default:   rdata = '0;
        endcase
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_CTRL) |=> (en_q == $past(wdata[CTRL_EN_BIT]))); // R10
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == RA_CTRL) |=> $stable(en_q)); // R9

endmodule

// File: rtl/rdocc_monitor.sv
module rdocc_monitor
    import rdocc_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int ACT_W = 48,
    parameter int SUM_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_req_acc,
    input  logic        rd_rsp_ret,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    ctrl_t            ctl;
    evt_t             evt;
    logic [CNT_W-1:0] inf_q;
    logic [CNT_W-1:0] peak_q;
    logic [ACT_W-1:0] act_q;
    logic [SUM_W-1:0] sum_q;

    assign evt.req = rd_req_acc;
    assign evt.rsp = rd_rsp_ret;

    rdocc_inflight #(.CNT_W(CNT_W)) u_inflight (
        .clk(clk), .rst(rst), .ctl(ctl), .evt(evt),
        .inf_q(inf_q), .peak_q(peak_q)
    );

    rdocc_integrator #(.CNT_W(CNT_W), .ACT_W(ACT_W), .SUM_W(SUM_W)) u_integ (
        .clk(clk), .rst(rst), .ctl(ctl), .inf_q(inf_q),
        .act_q(act_q), .sum_q(sum_q)
    );

    rdocc_regs #(.CNT_W(CNT_W), .ACT_W(ACT_W), .SUM_W(SUM_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .peak_q(peak_q), .act_q(act_q), .sum_q(sum_q),
        .ctl(ctl), .rdata(reg_rdata)
    );

endmodule

// File: tb/test_rdocc_monitor.sv
`timescale 1ns/1ps
module test_rdocc_monitor;
    localparam int CW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, rsp = 1'b0, wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;

    int tests = 0, fails = 0;
    int m_inf = 0, m_peak = 0;
    longint unsigned m_sum = 0, m_act = 0;
    bit m_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    rdocc_monitor #(.CNT_W(CW), .ACT_W(48), .SUM_W(64)) i_rdocc_monitor (
        .clk(clk), .rst(rst), .rd_req_acc(req), .rd_rsp_ret(rsp),
        .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit q, input bit s, input bit w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req = q; rsp = s; wr = w; addr = a; wdata = d;
        if (m_en) begin
            if (m_inf != 0) begin m_sum += m_inf; m_act++; end
            if (q && !s && m_inf < MAXV) m_inf++;
            else if (s && !q && m_inf > 0) m_inf--;
            if (m_inf > m_peak) m_peak = m_inf;
        end
        if (w && a == 3'd0) begin
            if (d[1]) begin m_inf = 0; m_peak = 0; m_sum = 0; m_act = 0; end
            m_en = d[0];
        end
        if (w && a == 3'd2) m_peak = 0;
        @(posedge clk);
        #1;
        req = 0; rsp = 0; wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic chk_all(input string tag);
        rd(3'd0, {tag, " ctrl"}, {31'd0, m_en});
        rd(3'd1, {tag, " act_lo"}, m_act[31:0]);
        rd(3'd2, {tag, " pack"}, {5'd0, 11'(m_peak), m_act[47:32]});
        rd(3'd3, {tag, " sum_lo"}, m_sum[31:0]);
        rd(3'd4, {tag, " sum_hi"}, m_sum[63:32]);
    endtask

    initial begin
        #(200000 * 20);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk_all("R1");
        for (int a = 5; a < 8; a++) rd(3'(a), "R1 R8 spare", 32'd0);

        // strobes with counting off
        for (int i = 0; i < 6; i++) cyc(1, i[0], 0, 0, 0);
        chk_all("R7 off");

        cyc(0, 0, 1, 3'd0, 32'hFFFF_FFF1);   // enable; bit1 clear too
        chk_all("R8 R10 enable");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk_all("R2 R5 R6 mix");

        // saturation, including both strobes at the top
        for (int i = 0; i < MAXV + 5; i++) cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        chk_all("R3 sat");
        for (int i = 0; i < MAXV + 5; i++) cyc(0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk_all("R3 floor");

        // random walk sweep
        for (int p = 0; p < 40; p++) begin
            for (int i = 0; i < 50; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (p[1]) cyc(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], 0, 0, 0);
                else      cyc(lfsr[0] & lfsr[1], lfsr[2] | lfsr[3], 0, 0, 0);
            end
            chk_all("R4 R5 R6 sweep");
        end

        // peak clear alone, then alongside a request
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 1, 3'd2, 32'h1234_5678);
        chk_all("R9 clear");
        cyc(1, 0, 1, 3'd2, 32'd0);
        chk_all("R9 same-cycle");
        cyc(0, 0, 0, 0, 0);
        chk_all("R4 after clear");

        // writes to spare addresses
        cyc(1, 0, 1, 3'd6, 32'hFFFF_FFFF);
        chk_all("R8 spare write");

        // disable with reads outstanding
        cyc(0, 0, 1, 3'd0, 32'd0);
        for (int i = 0; i < 8; i++) cyc(i[0], i[1], 0, 0, 0);
        chk_all("R7 hold");

        cyc(0, 0, 1, 3'd0, 32'd2);
        chk_all("R10 clear");
        cyc(0, 0, 1, 3'd0, 32'd3);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
        chk_all("R10 restart");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule